// File: doc/BRIEF.md
# W-CDMA Frame Sync Marker Generator

This block derives the periodic timing markers of a 3GPP FDD chip stream from the chip clock itself. It runs three nested counters: chips within a slot, slots within a radio frame, and frames within a system-frame-number cycle. Alongside them, a fourth counter repeats with a length programmed in chips. Each counter decodes a one-chip-wide high pulse on the first chip of its period. Together these give a slot marker, a frame marker, a frame-number restart marker and a sequence-repetition marker.

The trigger controller pulses a restart input when playback begins. That realigns every counter, so the chip after the restart carries all four markers at once. Two trigger outputs each choose one of the four markers, or a constant low, through their own select input. At the default sizes a slot is 2560 chips, a frame is 15 slots (38400 chips), and the frame-number counter is 12 bits wide.

Top module: `wsm_top`

## Requirements
- R1: While reset is low, and on the first chip after reset is released, `slot_o`, `frame_o`, `seq_o` and `sfn_o` are all high.
- R2: `slot_o` is high for exactly one chip in every `SLOT_CHIPS` chips (default 2560), on the first chip of each slot.
- R3: `frame_o` is high for one chip in every `SLOT_CHIPS*SLOTS_PER_FRAME` chips (default 15 slots, 38400 chips), and only on a chip where `slot_o` is also high.
- R4: `sfn_o` is high for one chip in every `SFN_PERIOD` frames (default 4096, a 12-bit frame count), on the first chip of the frame whose count wraps to 0, and only together with `frame_o`.
- R5: `seq_o` is high on every chip whose index since the last realignment is a multiple of `seq_len_i`. A `seq_len_i` of 0 or 1 makes `seq_o` high on every chip.
- R6: When `restart_i` is high at a clock edge, every counter returns to zero. The next chip therefore has all four markers high, and counting resumes from that chip.
- R7: `trig_a_o` follows the marker chosen by `sel_a_i` in the same cycle. The select codes are 0 for constant low, 1 for slot, 2 for frame, 3 for sequence and 4 for frame-number restart. Codes 5 to 7 also give constant low.
- R8: `trig_b_o` is driven by `sel_b_i` with the same codes, independently of `sel_a_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Chip clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| restart_i | input | 1 | Synchronous realignment of all counters |
| seq_len_i | input | SEQ_W | Length in chips of the played sequence |
| sel_a_i | input | 3 | Marker select for trigger output A |
| sel_b_i | input | 3 | Marker select for trigger output B |
| slot_o | output | 1 | First chip of a slot |
| frame_o | output | 1 | First chip of a radio frame |
| seq_o | output | 1 | First chip of a sequence repetition |
| sfn_o | output | 1 | First chip of frame number 0 |
| trig_a_o | output | 1 | Routed marker A |
| trig_b_o | output | 1 | Routed marker B |

## Verification
The markers are decoded without further registers from counter state. They therefore change one clock edge after the chip that advanced the counters, and a restart shows all markers high on the chip right after the edge that sampled it. The trigger outputs add no delay relative to their select inputs. The bench drives stimulus on the falling edge and checks one time unit later, so the expected chip index is the number of rising edges since the last realignment. It sweeps a reduced configuration (4-chip slots, 3-slot frames, 4-frame number cycle) over several sequence lengths and all eight select codes.

// File: rtl/wsm_pkg.sv
package wsm_pkg;
  typedef enum logic [2:0] {
    SEL_OFF   = 3'd0,
    SEL_SLOT  = 3'd1,
    SEL_FRAME = 3'd2,
    SEL_SEQ   = 3'd3,
    SEL_SFN   = 3'd4
  } trig_sel_e;

  typedef struct packed {
    logic sfn;
    logic seq;
    logic frame;
    logic slot;
  } marker_t;
endpackage

// File: rtl/wsm_mod_counter.sv
module wsm_mod_counter #(
  parameter int MOD = 4,
  parameter int CW  = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          en_i,
  output logic [CW-1:0] cnt_o
);
  logic [CW-1:0] cnt_q;
  logic          last;

  assign last  = (cnt_q == CW'(MOD - 1));
  assign cnt_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (en_i)  cnt_q <= last ? '0 : cnt_q + CW'(1);
  end
endmodule

// File: rtl/wsm_seq_counter.sv
module wsm_seq_counter #(
  parameter int SEQ_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [SEQ_W-1:0] len_i,
  output logic             start_o
);
  logic [SEQ_W-1:0] cnt_q;
  logic [SEQ_W:0]   nxt;
  logic             wrap;

  assign nxt     = {1'b0, cnt_q} + (SEQ_W+1)'(1);
  // >= rather than == so a shortened length wraps at once; 0 acts as 1
  assign wrap    = (nxt >= {1'b0, len_i});
  assign start_o = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else            cnt_q <= wrap ? '0 : nxt[SEQ_W-1:0];
  end
endmodule

// File: rtl/wsm_trig_route.sv
module wsm_trig_route
  import wsm_pkg::*;
(
  input  marker_t    mk_i,
  input  logic [2:0] sel_i,
  output logic       trig_o
);
  always_comb begin
    case (trig_sel_e'(sel_i))
      SEL_SLOT:  trig_o = mk_i.slot;
      SEL_FRAME: trig_o = mk_i.frame;
      SEL_SEQ:   trig_o = mk_i.seq;
      SEL_SFN:   trig_o = mk_i.sfn;
      default:   trig_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/wsm_top.sv
module wsm_top
  import wsm_pkg::*;
#(
  parameter int SLOT_CHIPS      = 2560,
  parameter int SLOTS_PER_FRAME = 15,
  parameter int SFN_PERIOD      = 4096,
  parameter int SEQ_W           = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic [SEQ_W-1:0] seq_len_i,
  input  logic [2:0]       sel_a_i,
  input  logic [2:0]       sel_b_i,
  output logic             slot_o,
  output logic             frame_o,
  output logic             seq_o,
  output logic             sfn_o,
  output logic             trig_a_o,
  output logic             trig_b_o
);
  localparam int CHIP_W = (SLOT_CHIPS > 1) ? $clog2(SLOT_CHIPS) : 1;
  localparam int SLOT_W = (SLOTS_PER_FRAME > 1) ? $clog2(SLOTS_PER_FRAME) : 1;
  localparam int SFN_W  = (SFN_PERIOD > 1) ? $clog2(SFN_PERIOD) : 1;
  localparam int N_OUT  = 2;

  logic [CHIP_W-1:0] chip_cnt;
  logic [SLOT_W-1:0] slot_cnt;
  logic [SFN_W-1:0]  sfn_cnt;
  logic              chip_last, slot_last, seq_start;
  marker_t           mk;
  logic [2:0]        sel [N_OUT];
  logic [N_OUT-1:0]  trig;

  assign chip_last = (chip_cnt == CHIP_W'(SLOT_CHIPS - 1));
  assign slot_last = (slot_cnt == SLOT_W'(SLOTS_PER_FRAME - 1));

  wsm_mod_counter #(.MOD(SLOT_CHIPS), .CW(CHIP_W)) u_chip (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(restart_i),
    .en_i(1'b1), .cnt_o(chip_cnt)
  );

  wsm_mod_counter #(.MOD(SLOTS_PER_FRAME), .CW(SLOT_W)) u_slot (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(restart_i),
    .en_i(chip_last), .cnt_o(slot_cnt)
  );

  wsm_mod_counter #(.MOD(SFN_PERIOD), .CW(SFN_W)) u_sfn (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(restart_i),
    .en_i(chip_last & slot_last), .cnt_o(sfn_cnt)
  );

  wsm_seq_counter #(.SEQ_W(SEQ_W)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(restart_i),
    .len_i(seq_len_i), .start_o(seq_start)
  );

  assign mk.slot  = (chip_cnt == '0);
  assign mk.frame = mk.slot & (slot_cnt == '0);
  assign mk.sfn   = mk.frame & (sfn_cnt == '0);
  assign mk.seq   = seq_start;

  assign sel[0] = sel_a_i;
  assign sel[1] = sel_b_i;

  for (genvar g = 0; g < N_OUT; g++) begin : g_route
    wsm_trig_route u_route (.mk_i(mk), .sel_i(sel[g]), .trig_o(trig[g]));
  end

  assign slot_o   = mk.slot;
  assign frame_o  = mk.frame;
  assign seq_o    = mk.seq;
  assign sfn_o    = mk.sfn;
  assign trig_a_o = trig[0];
  assign trig_b_o = trig[1];
endmodule

// File: rtl/wsm_checker.sv
module wsm_checker #(
  parameter int SLOT_CHIPS = 2560
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       restart_i,
  input logic [2:0] sel_a_i,
  input logic [2:0] sel_b_i,
  input logic       slot_o,
  input logic       frame_o,
  input logic       seq_o,
  input logic       sfn_o,
  input logic       trig_a_o,
  input logic       trig_b_o
);
  localparam int GW = $clog2(SLOT_CHIPS + 1) + 1;
  logic [GW-1:0] gap_q;

  // chips since the last slot marker; primed so the first chip after realignment is due
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        gap_q <= GW'(SLOT_CHIPS - 1);
    else if (restart_i) gap_q <= GW'(SLOT_CHIPS - 1);
    else if (slot_o)    gap_q <= '0;
    else                gap_q <= gap_q + GW'(1);
  end

  assert_slot_spacing_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_o == (gap_q == GW'(SLOT_CHIPS - 1)));

  assert_frame_on_slot_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_o |-> slot_o);

  assert_sfn_on_frame_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sfn_o |-> frame_o);

  assert_restart_aligns_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (slot_o && frame_o && seq_o && sfn_o));

  assert_route_a_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_a_o |-> ((sel_a_i == 3'd1 && slot_o) || (sel_a_i == 3'd2 && frame_o) ||
                  (sel_a_i == 3'd3 && seq_o)  || (sel_a_i == 3'd4 && sfn_o)));

  assert_route_b_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_b_i == 3'd1) |-> (trig_b_o == slot_o));
endmodule

bind wsm_top wsm_checker #(.SLOT_CHIPS(SLOT_CHIPS)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .restart_i(restart_i),
  .sel_a_i(sel_a_i), .sel_b_i(sel_b_i),
  .slot_o(slot_o), .frame_o(frame_o), .seq_o(seq_o), .sfn_o(sfn_o),
  .trig_a_o(trig_a_o), .trig_b_o(trig_b_o)
);

// File: tb/wsm_top_tb.sv
module wsm_top_tb;
  localparam int SC = 4, SPF = 3, SP = 4, SW = 8;
  localparam int FC = SC * SPF, NC = FC * SP;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b1;
  logic          restart_i = 1'b0;
  logic [SW-1:0] seq_len_i = '0;
  logic [2:0]    sel_a_i = '0, sel_b_i = '0;
  logic          slot_o, frame_o, seq_o, sfn_o, trig_a_o, trig_b_o;
  int            checks = 0, errors = 0;

  always #10 clk_i = ~clk_i;

  wsm_top #(.SLOT_CHIPS(SC), .SLOTS_PER_FRAME(SPF), .SFN_PERIOD(SP), .SEQ_W(SW)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .restart_i(restart_i), .seq_len_i(seq_len_i),
    .sel_a_i(sel_a_i), .sel_b_i(sel_b_i), .slot_o(slot_o), .frame_o(frame_o),
    .seq_o(seq_o), .sfn_o(sfn_o), .trig_a_o(trig_a_o), .trig_b_o(trig_b_o)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic pick(input int sel, input logic s, input logic f,
                                input logic q, input logic n);
    case (sel)
      1: return s;
      2: return f;
      3: return q;
      4: return n;
      default: return 1'b0;
    endcase
  endfunction

  // k = chips since last realignment; checks at falling edge + 1
  task automatic play(input int len, input int n, input bit do_restart);
    int lm;
    lm = (len < 2) ? 1 : len;
    seq_len_i = SW'(len);
    if (do_restart) begin
      restart_i = 1'b1;
      @(negedge clk_i);
      restart_i = 1'b0;
    end
    for (int k = 0; k < n; k++) begin
      logic es, ef, eq, en;
      sel_a_i = 3'(k % 8);
      sel_b_i = 3'((k + 3) % 8);
      #1;
      es = (k % SC) == 0;
      ef = (k % FC) == 0;
      en = (k % NC) == 0;
      eq = (k % lm) == 0;
      if (k == 0 && do_restart) chk("R6 all markers after restart", slot_o & frame_o & seq_o & sfn_o, 1'b1);
      chk("R2 slot", slot_o, es);
      chk("R3 frame", frame_o, ef);
      chk("R4 sfn", sfn_o, en);
      chk("R5 seq", seq_o, eq);
      chk("R7 trig_a", trig_a_o, pick(k % 8, es, ef, eq, en));
      chk("R8 trig_b", trig_b_o, pick((k + 3) % 8, es, ef, eq, en));
      @(negedge clk_i);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: run incomplete, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1 rst_ni = 1'b0;
    seq_len_i = SW'(5);
    repeat (3) @(negedge clk_i);
    #1;
    chk("R1 slot in reset", slot_o, 1'b1);
    chk("R1 frame in reset", frame_o, 1'b1);
    chk("R1 seq in reset", seq_o, 1'b1);
    chk("R1 sfn in reset", sfn_o, 1'b1);
    @(negedge clk_i);
    rst_ni = 1'b1;
    #1;
    chk("R1 all markers first chip", slot_o & frame_o & seq_o & sfn_o, 1'b1);
    play(5, 120, 1'b0);
    play(0, 40, 1'b1);
    play(1, 30, 1'b1);
    play(3, 13, 1'b1);   // restart mid-slot next
    play(7, 150, 1'b1);
    play(12, 110, 1'b1);
    play(48, 100, 1'b1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule